// File: doc/BRIEF.md
# Serial Peripheral Master Engine with Selectable Word Length

This block drives a four-wire serial peripheral bus as the clock master. Words written into a small transmit queue are shifted out on MOSI, most significant bit first, while MISO is captured into a receive word. Each completed receive word lands in a receive queue. As long as the transmit queue has data, words follow each other with no idle gap on the serial clock. Draining the transmit queue ends the burst.

Software-visible settings arrive as plain inputs, and each one is captured at the start of every word. They are:
- a word length code (8, 16 or 32 bits);
- a 9-bit divider that sets the serial clock to the input clock divided by 2*(div+1);
- the idle clock level;
- the edge that launches data;
- the receive sample point (middle or end of the bit).

An optional hardware chip select is held low for the duration of a burst. The engine runs only when both the enable input and the master input are high.

Top module: `spi_word_master`

## Requirements
- R1: While reset is held and until the first word starts, sck equals cfg_cpol, mosi is 0, cs_n is 1, rx_empty is 1 and tx_full is 0. The internal reset is released on the second clock edge after rst_n rises.
- R2: Every half period of sck lasts exactly cfg_div+1 clock cycles, giving a serial clock of clk/(2*(cfg_div+1)).
- R3: The cfg_wlen code selects the word length. Code 0 selects 8 bits, code 1 selects 16 bits and code 2 selects 32 bits; code 3 is treated as 8 bits. The word is taken from the low bits of tx_wdata and sent MSB first, and mosi changes only at bit boundaries.
- R4: While idle, sck rests at cfg_cpol. During a word, the first half of every bit has sck = cfg_cpol XOR cfg_cpha and the second half has the inverse level. cfg_cpha=1 therefore launches data on the edge leaving idle, and cfg_cpha=0 launches it on the edge returning to idle.
- R5: With cfg_smp_end=0, miso is sampled on the last clock of each bit's first half. With cfg_smp_end=1, it is sampled on the last clock of the second half. Every sent word yields exactly one received word, right-aligned with the first sampled bit as its MSB and zeros above the word length.
- R6: When a word ends and the transmit queue is not empty, the next word starts in the very next clock cycle. The first half of its first bit then begins with no extra idle cycle.
- R7: cs_n is 0 only while the engine runs, cfg_hw_cs is 1, and either the transmit queue holds data or a word is in progress. In every other case cs_n is 1.
- R8: When cfg_enable or cfg_master is 0, no shifting occurs, and sck, mosi and cs_n are at their idle values in that same cycle. A word that is in progress is discarded without producing a received word. Queued transmit words are kept.
- R9: Word length, divider, clock level, launch edge and sample point are captured when a word starts. Changing them mid-word has no effect until the next word.
- R10: A push into a full transmit queue is ignored, and so is a pop from an empty receive queue. A received word that arrives while the receive queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable |
| cfg_master | input | 1 | Master operation enable |
| cfg_hw_cs | input | 1 | Hardware chip select enable |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | Launch edge select |
| cfg_smp_end | input | 1 | Sample at end of bit instead of middle |
| cfg_wlen | input | 2 | Word length code |
| cfg_div | input | DIV_W | Serial clock divider |
| tx_push | input | 1 | Write tx_wdata into the transmit queue |
| tx_wdata | input | 32 | Transmit word, right-aligned |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_rdata | output | 32 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Hardware chip select, active low |

## Verification
Some properties are checked on every cycle:
- the sck half-period spacing;
- that the latched word settings and the outgoing data bit stay put between bit boundaries;
- that the queue occupancy stays within bounds;
- that sck, mosi and cs_n are idle whenever the engine is not allowed to run.

Other behaviours show only through the bench's scenarios, against a behavioural cycle model:
- the exact bit order and received word value for each length and sample point;
- the absence of a gap between back-to-back words;
- the chip select spanning a burst;
- dropping a word when the enable input falls mid-word;
- settings that change mid-word taking effect only on the following word.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int unsigned WORD_MAX = 32;
  localparam int unsigned BITCNT_W = $clog2(WORD_MAX) + 1;

  typedef enum logic [1:0] {
    WL_8   = 2'd0,
    WL_16  = 2'd1,
    WL_32  = 2'd2,
    WL_RSV = 2'd3
  } wlen_e;

  // word length in bits for a length code; the reserved code maps to 8
  function automatic logic [BITCNT_W-1:0] word_bits(input logic [1:0] code);
    logic [BITCNT_W-1:0] nb;
    case (wlen_e'(code))
      WL_16:   nb = BITCNT_W'(16);
      WL_32:   nb = BITCNT_W'(32);
      default: nb = BITCNT_W'(8);
    endcase
    return nb;
  endfunction
endpackage

// File: rtl/swm_fifo.sv
module swm_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr_q];

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push_ok) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_n = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (empty && $stable(rptr_q)));
endmodule

// File: rtl/swm_baud.sv
module swm_baud #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n, div_q, div_n;

  assign tick = active && (cnt_q == div_q);

  always_comb begin
    cnt_n = cnt_q;
    div_n = div_q;
    if (load) begin
      cnt_n = '0;
      div_n = div_in;
    end else if (!active || tick) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      div_q <= div_n;
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && div_q != '0) |=> !tick);

  assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |=> $stable(div_q));
endmodule

// File: rtl/swm_shifter.sv
module swm_shifter
  import swm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic                tx_empty,
  input  logic [WORD_MAX-1:0] tx_data,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_smp_end,
  input  logic                miso,
  output logic                tx_pop,
  output logic                load,
  output logic                busy,
  output logic                rx_push,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                sck,
  output logic                mosi
);
  logic                busy_q, busy_n, phase_q, phase_n;
  logic                lead_q, lead_n, smp_q, smp_n, start;
  logic [BITCNT_W-1:0] bitcnt_q, bitcnt_n, nbits_q, nbits_n, nb_new;
  logic [WORD_MAX-1:0] txsh_q, txsh_n, rxsh_q, rxsh_n, rx_in, rx_word, mask;

  assign nb_new = word_bits(cfg_wlen);
  assign rx_in  = {rxsh_q[WORD_MAX-2:0], miso};
  assign mask   = {WORD_MAX{1'b1}} >> (WORD_MAX - int'(nbits_q));
  assign busy   = busy_q;
  assign sck    = (busy_q && run) ? (phase_q ? ~lead_q : lead_q) : cfg_cpol;
  assign mosi   = busy_q && run && txsh_q[WORD_MAX-1];

  always_comb begin
    busy_n   = busy_q;
    phase_n  = phase_q;
    bitcnt_n = bitcnt_q;
    nbits_n  = nbits_q;
    txsh_n   = txsh_q;
    rxsh_n   = rxsh_q;
    lead_n   = lead_q;
    smp_n    = smp_q;
    start    = 1'b0;
    rx_push  = 1'b0;
    rx_word  = smp_q ? rx_in : rxsh_q;
    rx_data  = '0;
    if (!run) begin
      busy_n = 1'b0;
    end else if (!busy_q) begin
      start = !tx_empty;
    end else if (tick) begin
      if (!phase_q) begin
        phase_n = 1'b1;
        if (!smp_q) rxsh_n = rx_in;
      end else begin
        rxsh_n = rx_word;
        if (bitcnt_q == '0) begin
          rx_push = 1'b1;
          rx_data = rx_word & mask;
          if (!tx_empty) start = 1'b1;
          else busy_n = 1'b0;
        end else begin
          bitcnt_n = bitcnt_q - 1'b1;
          phase_n  = 1'b0;
          txsh_n   = txsh_q << 1;
        end
      end
    end
    if (start) begin
      busy_n   = 1'b1;
      phase_n  = 1'b0;
      nbits_n  = nb_new;
      bitcnt_n = nb_new - 1'b1;
      txsh_n   = tx_data << (WORD_MAX - int'(nb_new));
      lead_n   = cfg_cpol ^ cfg_cpha;
      smp_n    = cfg_smp_end;
    end
  end

  assign load   = start;
  assign tx_pop = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      phase_q  <= 1'b0;
      bitcnt_q <= '0;
      nbits_q  <= BITCNT_W'(8);
      txsh_q   <= '0;
      rxsh_q   <= '0;
      lead_q   <= 1'b0;
      smp_q    <= 1'b0;
    end else begin
      busy_q   <= busy_n;
      phase_q  <= phase_n;
      bitcnt_q <= bitcnt_n;
      nbits_q  <= nbits_n;
      txsh_q   <= txsh_n;
      rxsh_q   <= rxsh_n;
      lead_q   <= lead_n;
      smp_q    <= smp_n;
    end
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> ($stable(nbits_q) && $stable(lead_q) && $stable(smp_q)));

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && run && !tick) |=> $stable(txsh_q[WORD_MAX-1]));

  assert_word_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bitcnt_q < nbits_q));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import swm_pkg::*;
#(
  parameter int unsigned DIV_W      = 9,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_master,
  input  logic                cfg_hw_cs,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_smp_end,
  input  logic [1:0]          cfg_wlen,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                tx_push,
  input  logic [WORD_MAX-1:0] tx_wdata,
  output logic                tx_full,
  input  logic                rx_pop,
  output logic [WORD_MAX-1:0] rx_rdata,
  output logic                rx_empty,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n, run, tick, load, busy;
  logic                  tx_pop, tx_empty, rx_push;
  logic [WORD_MAX-1:0]   tx_head, rx_word;

  // asynchronous assertion, synchronous release
  generate
    for (genvar s = 0; s < RST_STAGES; s++) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q[s] <= 1'b0;
        else        rst_sync_q[s] <= (s == 0) ? 1'b1 : rst_sync_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  assign run  = cfg_enable && cfg_master;
  assign cs_n = !(run && cfg_hw_cs && (busy || !tx_empty));

  swm_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_int_n), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  swm_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_int_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_rdata), .empty(rx_empty), .full());

  swm_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_int_n), .load(load), .active(busy),
    .div_in(cfg_div), .tick(tick));

  swm_shifter shifter_i (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick),
    .tx_empty(tx_empty), .tx_data(tx_head), .cfg_wlen(cfg_wlen),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_smp_end(cfg_smp_end),
    .miso(miso), .tx_pop(tx_pop), .load(load), .busy(busy),
    .rx_push(rx_push), .rx_data(rx_word), .sck(sck), .mosi(mosi));

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !run |-> (cs_n && !mosi && (sck == cfg_cpol)));

  assert_cs_burst_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && cfg_hw_cs && busy) |-> !cs_n);
endmodule

// File: tb/spi_word_master_tb_top.sv
module spi_word_master_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 0, cfg_master = 0, cfg_hw_cs = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_smp_end = 0;
  logic [1:0] cfg_wlen = 0;
  logic [8:0] cfg_div = 0;
  logic tx_push = 0, rx_pop = 0, miso = 0;
  logic [31:0] tx_wdata = 0;
  logic tx_full, rx_empty, sck, mosi, cs_n;
  logic [31:0] rx_rdata;

  always #4 clk = ~clk;

  spi_word_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_hw_cs(cfg_hw_cs), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_smp_end(cfg_smp_end), .cfg_wlen(cfg_wlen), .cfg_div(cfg_div),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_empty(rx_empty), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 0, done = 0;
  string scen = "R1 reset";
  logic [15:0] lfsr = 16'hACE1;

  // bench reference model state
  logic [31:0] txq[$], rxq[$];
  bit m_busy = 0, m_phase = 0, m_lead = 0, m_smp = 0;
  int m_cnt = 0, m_div = 0, m_bit = 0, m_nb = 8;
  logic [31:0] m_word = 0, m_rx = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %h expected %h", tag, scen, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'd1) ? 16 : (c == 2'd2) ? 32 : 8;
  endfunction

  function automatic logic [31:0] msk(input int nb);
    return (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  end

  task automatic m_start();
    m_word  = txq.pop_front();
    m_nb    = len_of(cfg_wlen);
    m_bit   = m_nb - 1;
    m_phase = 0;
    m_cnt   = 0;
    m_div   = int'(cfg_div);
    m_lead  = cfg_cpol ^ cfg_cpha;
    m_smp   = cfg_smp_end;
    m_busy  = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_busy = 0; m_phase = 0; m_cnt = 0; m_rx = 0;
    end else begin
      bit run, tx_emp, tx_fl, rx_fl, push_rx;
      logic [31:0] rword;
      run = cfg_enable && cfg_master;
      tx_emp = (txq.size() == 0);
      tx_fl = (txq.size() == DEPTH);
      rx_fl = (rxq.size() == DEPTH);
      push_rx = 0;
      rword = 0;
      if (!run) m_busy = 0;
      else if (!m_busy) begin
        if (!tx_emp) m_start();
      end else if (m_cnt != m_div) m_cnt++;
      else begin
        m_cnt = 0;
        if (!m_phase) begin
          m_phase = 1;
          if (!m_smp) m_rx = {m_rx[30:0], miso};
        end else begin
          if (m_smp) m_rx = {m_rx[30:0], miso};
          if (m_bit == 0) begin
            push_rx = 1;
            rword = m_rx & msk(m_nb);
            if (!tx_emp) m_start(); else m_busy = 0;
          end else begin
            m_bit--;
            m_phase = 0;
          end
        end
      end
      if (rx_pop && rxq.size() != 0) void'(rxq.pop_front());
      if (push_rx && !rx_fl) rxq.push_back(rword);
      if (tx_push && !tx_fl) txq.push_back(tx_wdata);
    end
  end

  // compare outputs with the model away from the clock edge
  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      bit run;
      run = cfg_enable && cfg_master;
      chk("R2 R4 sck", {31'd0, sck},
          {31'd0, (m_busy && run) ? (m_phase ? ~m_lead : m_lead) : cfg_cpol});
      chk("R3 mosi", {31'd0, mosi}, {31'd0, m_busy && run && m_word[m_bit]});
      chk("R7 cs_n", {31'd0, cs_n},
          {31'd0, !(run && cfg_hw_cs && (m_busy || txq.size() != 0))});
      chk("R5 rx_empty", {31'd0, rx_empty}, {31'd0, rxq.size() == 0});
      chk("R10 tx_full", {31'd0, tx_full}, {31'd0, txq.size() == DEPTH});
      if (rxq.size() != 0) chk("R5 rx_rdata", rx_rdata, rxq[0]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL R6 watchdog expired: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic push(input logic [31:0] d);
    @(negedge clk); tx_push = 1; tx_wdata = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (m_busy || txq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    while (rxq.size() != 0) pop();
  endtask

  task automatic setup(input bit pol, input bit pha, input bit se, input logic [1:0] wl,
                       input logic [8:0] dv, input bit hcs);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_smp_end = se; cfg_wlen = wl;
    cfg_div = dv; cfg_hw_cs = hcs;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sck", {31'd0, sck}, 32'd0);
    chk("R1 mosi", {31'd0, mosi}, 32'd0);
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 rx_empty", {31'd0, rx_empty}, 32'd1);
    chk("R1 tx_full", {31'd0, tx_full}, 32'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    cmp_en = 1;

    scen = "R6 R3 8-bit back-to-back mode0";
    setup(0, 0, 0, 2'd0, 9'd0, 1);
    cfg_master = 1; cfg_enable = 1;
    push(32'h0000_00A5); push(32'hFFFF_FF3C); push(32'h0000_0081);
    wait_done(); drain();

    scen = "R5 16-bit idle high launch leading sample end";
    setup(1, 1, 1, 2'd1, 9'd2, 1);
    push(32'h0000_BEEF); push(32'h0000_1234);
    wait_done(); drain();

    scen = "R2 32-bit div1 sample middle";
    setup(0, 1, 0, 2'd2, 9'd1, 1);
    push(32'hDEAD_C0DE); push(32'h8000_0001);
    wait_done(); drain();

    scen = "R3 reserved code acts as 8-bit";
    setup(1, 0, 1, 2'd3, 9'd0, 1);
    push(32'h1234_5696);
    wait_done(); drain();

    scen = "R9 settings changed mid-word";
    setup(0, 0, 0, 2'd0, 9'd1, 1);
    push(32'h0000_00C3); push(32'h0000_5A5A);
    repeat (6) @(negedge clk);
    cfg_wlen = 2'd1; cfg_div = 9'd0; cfg_cpol = 1; cfg_smp_end = 1;
    wait_done(); drain();

    scen = "R7 no hardware chip select";
    setup(0, 0, 0, 2'd0, 9'd0, 0);
    push(32'h0000_0055);
    repeat (4) @(negedge clk);
    chk("R7 cs_n held high", {31'd0, cs_n}, 32'd1);
    wait_done(); drain();

    scen = "R10 queue limits";
    setup(0, 0, 0, 2'd0, 9'd0, 1);
    cfg_enable = 0;
    for (int i = 0; i < 5; i++) push(32'h10 + i);
    chk("R10 tx full after overfill", {31'd0, tx_full}, 32'd1);
    cfg_enable = 1;
    wait_done();
    push(32'h0000_00EE);
    wait_done();
    chk("R10 rx holds four words", rxq.size(), 32'd4);
    drain();
    pop();
    chk("R10 pop on empty", {31'd0, rx_empty}, 32'd1);

    scen = "R8 abort and master gate";
    setup(0, 0, 0, 2'd2, 9'd3, 1);
    push(32'hCAFE_F00D);
    repeat (40) @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
    chk("R8 cs released", {31'd0, cs_n}, 32'd1);
    chk("R8 sck idle", {31'd0, sck}, {31'd0, cfg_cpol});
    repeat (5) @(negedge clk);
    chk("R8 word discarded", {31'd0, rx_empty}, 32'd1);
    cfg_master = 0; cfg_enable = 1;
    push(32'h0000_0077);
    repeat (10) @(negedge clk);
    chk("R8 no shift without master", {31'd0, rx_empty}, 32'd1);
    chk("R8 cs high without master", {31'd0, cs_n}, 32'd1);
    cfg_wlen = 2'd0;
    cfg_master = 1;
    wait_done();
    chk("R8 queued word kept", rxq.size(), 32'd1);
    drain();

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule